// File: doc/BRIEF.md
# Write-Masked Bus Idle Request Controller

This block holds one bus idle request bit per power domain and drives those bits out as a request vector toward the bus interconnect. Software reaches it through a simple register port. The control word has two halves. The low 16 bits carry request data. The high 16 bits carry a write enable for each data bit. A single write can therefore set or clear any group of requests, and the bits it does not enable stay as they were. No read-modify-write is needed.

The interconnect answers each request with an acknowledge line and an idle line. Both pass through a synchronizer and appear in one read-only status word. For a domain, the acknowledge flag and the idle flag sit at different bit positions in that word. Some request positions have no domain behind them. Those positions are skipped: they never hold a request and report no status.

Top module: `bir_ctrl`

## Requirements
- R1: While reset is low, and after it is released, every request output is 0 and the control register reads 0.
- R2: On a write to the control register (byte offset 0x414), data bit n (wdata bit n) changes only when wdata bit n+16 is 1. Every other request bit keeps its previous value.
- R3: Writing data bit n together with enable bit n+16 sets request n. Writing enable bit n+16 with data bit n at 0 clears request n. The request output follows on the clock edge that takes the write.
- R4: A control register read returns the current request state in bits 9:0 and zeros in bits 31:10. This includes the enable half, bits 31:16. Read data appears one clock after the read strobe.
- R5: Only request positions 0 to 6, 8 and 9 have a domain. Position 7 is unused: writes to it have no effect, its request output stays 0 and it reads back 0.
- R6: The status register (byte offset 0x484) reports the synchronized acknowledge of domain r at bit r and its idle flag at bit r+10. Unused position 7 reports 0 at bits 7 and 17, and bits 31:20 read 0.
- R7: The status register is read-only. A write to offset 0x484 leaves every request unchanged.
- R8: The acknowledge and idle inputs pass through a two-flop synchronizer. After a change on these inputs, reads sampled at the first and second rising edges still return the old status. The read sampled at the third rising edge returns the new status.
- R9: A write to any offset other than 0x414 changes no request. A read from any offset other than 0x414 or 0x484 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data: data in bits 15:0, per-bit enable in bits 31:16 |
| rdata_o | output | 32 | Read data, valid one clock after rd_en_i |
| req_o | output | 10 | Idle request to each domain |
| ack_i | input | 10 | Acknowledge from the interconnect for each domain |
| idle_i | input | 10 | Idle indication from the interconnect for each domain |

## Verification
A request bit can be corrupted in two ways: by a write whose enable bit was 0, or by a write whose enable went to the wrong bit. Either fault shows on req_o at the very edge that takes the write. It also shows in the next control readback one cycle later, so the bench compares req_o after every write. A shuffled or dropped status position is only seen when a read happens. An extra or missing synchronizer stage moves the moment the status changes by exactly one read. For that reason the bench reads the status at the first, second and third edge after an input change.

// File: rtl/bir_pkg.sv
package bir_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT
  } sel_e;

  // per-bit masked update: enabled bits take new data, others hold
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_v,
    input logic [HALF_W-1:0] new_v,
    input logic [HALF_W-1:0] en_v
  );
    return (old_v & ~en_v) | (new_v & en_v);
  endfunction
endpackage

// File: rtl/bir_sync.sv
module bir_sync #(
  parameter int unsigned WIDTH  = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bir_req_reg.sv
module bir_req_reg #(
  parameter int unsigned        NUM_DOM   = 10,
  parameter logic [NUM_DOM-1:0] USED_MASK = 10'h37F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_DOM-1:0] data_i,
  input  logic [NUM_DOM-1:0] en_i,
  output logic [NUM_DOM-1:0] req_o
);
  import bir_pkg::*;

  logic [HALF_W-1:0] merged;
  assign merged = masked_merge(HALF_W'(req_o), HALF_W'(data_i), HALF_W'(en_i));

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_bit
    if (USED_MASK[g]) begin : g_used
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   bit_q <= 1'b0;
        else if (wr_i) bit_q <= merged[g];
      end
      assign req_o[g] = bit_q;
    end else begin : g_skip
      assign req_o[g] = 1'b0;
    end
  end

  logic unused_merge;
  assign unused_merge = ^merged;
endmodule

// File: rtl/bir_status.sv
module bir_status #(
  parameter int unsigned        NUM_DOM    = 10,
  parameter logic [NUM_DOM-1:0] USED_MASK  = 10'h37F,
  parameter int unsigned        IDLE_SHIFT = 10
) (
  input  logic [NUM_DOM-1:0]          ack_i,
  input  logic [NUM_DOM-1:0]          idle_i,
  output logic [bir_pkg::REG_W-1:0]   status_o
);
  import bir_pkg::*;

  logic [REG_W-1:0] ack_w, idle_w;

  assign ack_w    = REG_W'(ack_i & USED_MASK);
  assign idle_w   = REG_W'(idle_i & USED_MASK) << IDLE_SHIFT;
  assign status_o = ack_w | idle_w;
endmodule

// File: rtl/bir_ctrl.sv
module bir_ctrl #(
  parameter int unsigned        NUM_DOM     = 10,
  parameter logic [NUM_DOM-1:0] USED_MASK   = 10'h37F,
  parameter int unsigned        IDLE_SHIFT  = 10,
  parameter int unsigned        SYNC_STAGES = 2,
  parameter int unsigned        ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]  CTRL_OFF    = 12'h414,
  parameter logic [ADDR_W-1:0]  STAT_OFF    = 12'h484
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_DOM-1:0] req_o,
  input  logic [NUM_DOM-1:0] ack_i,
  input  logic [NUM_DOM-1:0] idle_i
);
  import bir_pkg::*;

  localparam int unsigned SYNC_W = 2 * NUM_DOM;
  localparam logic [REG_W-1:0] KEEP_BITS =
    REG_W'({NUM_DOM{1'b1}}) | (REG_W'({NUM_DOM{1'b1}}) << HALF_W);

  sel_e sel;
  always_comb begin
    unique case (addr_i)
      CTRL_OFF: sel = SEL_CTRL;
      STAT_OFF: sel = SEL_STAT;
      default:  sel = SEL_NONE;
    endcase
  end

  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (sel == SEL_CTRL);

  bir_req_reg #(
    .NUM_DOM   (NUM_DOM),
    .USED_MASK (USED_MASK)
  ) i_req_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .data_i (wdata_i[NUM_DOM-1:0]),
    .en_i   (wdata_i[HALF_W +: NUM_DOM]),
    .req_o  (req_o)
  );

  logic [SYNC_W-1:0] sync_q;
  bir_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({idle_i, ack_i}),
    .q_o    (sync_q)
  );

  logic [REG_W-1:0] stat_word;
  bir_status #(
    .NUM_DOM    (NUM_DOM),
    .USED_MASK  (USED_MASK),
    .IDLE_SHIFT (IDLE_SHIFT)
  ) i_status (
    .ack_i    (sync_q[NUM_DOM-1:0]),
    .idle_i   (sync_q[SYNC_W-1:NUM_DOM]),
    .status_o (stat_word)
  );

  logic [REG_W-1:0] ctrl_word, rd_next, rdata_q;
  assign ctrl_word = REG_W'(req_o);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_next = ctrl_word;
      SEL_STAT: rd_next = stat_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  // write bits beyond the populated domains carry no state
  logic unused_wbits;
  assign unused_wbits = ^(wdata_i & ~KEEP_BITS);
endmodule

// File: rtl/bir_ctrl_chk.sv
module bir_ctrl_chk #(
  parameter int unsigned        NUM_DOM   = 10,
  parameter logic [NUM_DOM-1:0] USED_MASK = 10'h37F,
  parameter int unsigned        ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  CTRL_OFF  = 12'h414,
  parameter logic [ADDR_W-1:0]  STAT_OFF  = 12'h484
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_DOM-1:0] req_o
);
  logic ctl_w, ctl_r, bad_r;
  assign ctl_w = wr_en_i && (addr_i == CTRL_OFF);
  assign ctl_r = rd_en_i && (addr_i == CTRL_OFF);
  assign bad_r = rd_en_i && (addr_i != CTRL_OFF) && (addr_i != STAT_OFF);

  AST_KEEP_UNENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_w |=> ((req_o ^ $past(req_o)) & ~$past(wdata_i[16 +: NUM_DOM])) == '0); // R2

  AST_TAKE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_w |=> ((req_o ^ $past(wdata_i[NUM_DOM-1:0])) & $past(wdata_i[16 +: NUM_DOM]) & USED_MASK) == '0); // R3

  AST_UNUSED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & ~USED_MASK) == '0); // R5

  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_w |=> $stable(req_o)); // R7

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_r |=> rdata_o[31:NUM_DOM] == '0); // R4

  AST_CTRL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_r |=> rdata_o[NUM_DOM-1:0] == $past(req_o)); // R4

  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_r |=> rdata_o == '0); // R9
endmodule

bind bir_ctrl bir_ctrl_chk #(
  .NUM_DOM   (NUM_DOM),
  .USED_MASK (USED_MASK),
  .ADDR_W    (ADDR_W),
  .CTRL_OFF  (CTRL_OFF),
  .STAT_OFF  (STAT_OFF)
) i_bir_ctrl_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .req_o   (req_o)
);

// File: tb/test_bir_ctrl.sv
module test_bir_ctrl;
  localparam logic [9:0]  MASK = 10'h37F;
  localparam logic [11:0] A_CTRL = 12'h414;
  localparam logic [11:0] A_STAT = 12'h484;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [9:0]  req_o;
  logic [9:0]  ack_i = '0, idle_i = '0;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [9:0]  exp_req = '0;
  logic [31:0] rd_val;

  always #10 clk_i = ~clk_i;

  bir_ctrl i_bir_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .req_o(req_o),
    .ack_i(ack_i), .idle_i(idle_i)
  );

  function automatic logic [9:0] model_req(logic [9:0] old_v, logic [31:0] w);
    logic [9:0] d = w[9:0];
    logic [9:0] e = w[25:16];
    return ((old_v & ~e) | (d & e)) & MASK;
  endfunction

  function automatic logic [31:0] model_stat(logic [9:0] a, logic [9:0] i);
    return {12'h000, i & MASK, a & MASK};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called and returns at a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    d = rdata_o; rd_en_i = 1'b0;
  endtask

  task automatic wr_ctrl(logic [31:0] d, string tag);
    wr(A_CTRL, d);
    exp_req = model_req(exp_req, d);
    check(tag, 32'(req_o), 32'(exp_req));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1e));
    repeat (3) @(negedge clk_i);
    check("R1 req in reset", 32'(req_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 req after reset", 32'(req_o), 32'h0);
    rd(A_CTRL, rd_val);
    check("R1 ctrl read after reset", rd_val, 32'h0);

    // R3 set then clear one request
    wr_ctrl(32'h0001_0001, "R3 set bit0");
    wr_ctrl(32'h0001_0000, "R3 clear bit0");

    // R2 only enabled bits move
    wr_ctrl(32'h03FF_03FF, "R2 set all used");
    check("R5 bit7 stays low", 32'(req_o[7]), 32'h0);
    wr_ctrl(32'h0004_03FB, "R2 clear only bit2");
    check("R2 exact value", 32'(req_o), 32'h37B);
    wr_ctrl(32'h0000_0000, "R2 no enables no change");

    // R5 unused position
    wr_ctrl(32'h0080_0080, "R5 write bit7");
    rd(A_CTRL, rd_val);
    check("R5 bit7 reads zero", 32'(rd_val[7]), 32'h0);

    // R4 upper half reads zero
    wr_ctrl(32'hFFFF_FFFF, "R4 all ones write");
    rd(A_CTRL, rd_val);
    check("R4 ctrl readback", rd_val, 32'h0000_037F);

    for (int k = 0; k < 200; k++) begin
      logic [31:0] w = $urandom;
      wr_ctrl(w, "R2 random masked write");
      if (k % 4 == 0) begin
        rd(A_CTRL, rd_val);
        check("R4 random readback", rd_val, 32'(exp_req));
      end
    end

    // R7 status read-only, R9 other offsets
    for (int k = 0; k < 8; k++) begin
      wr(A_STAT, $urandom | 32'hFFFF_0000);
      check("R7 status write ignored", 32'(req_o), 32'(exp_req));
    end
    wr(12'h418, 32'hFFFF_FFFF);
    check("R9 write other offset", 32'(req_o), 32'(exp_req));
    wr(12'h000, 32'hFFFF_0000);
    check("R9 write offset zero", 32'(req_o), 32'(exp_req));
    rd(A_CTRL, rd_val);
    check("R9 ctrl after stray writes", rd_val, 32'(exp_req));
    rd(12'h410, rd_val);
    check("R9 read other offset", rd_val, 32'h0);

    // R6 status layout
    ack_i = 10'h080; idle_i = 10'h080;
    repeat (3) @(negedge clk_i);
    rd(A_STAT, rd_val);
    check("R6 unused position status", rd_val, 32'h0);
    for (int k = 0; k < 60; k++) begin
      ack_i = 10'($urandom); idle_i = 10'($urandom);
      repeat (3) @(negedge clk_i);
      rd(A_STAT, rd_val);
      check("R6 random status", rd_val, model_stat(ack_i, idle_i));
    end

    // R8 synchronizer latency
    ack_i = '0; idle_i = '0;
    repeat (4) @(negedge clk_i);
    ack_i = 10'h3FF; idle_i = 10'h3FF;
    rd(A_STAT, rd_val);
    check("R8 first edge old", rd_val, 32'h0);
    rd(A_STAT, rd_val);
    check("R8 second edge old", rd_val, 32'h0);
    rd(A_STAT, rd_val);
    check("R8 third edge new", rd_val, model_stat(10'h3FF, 10'h3FF));

    // R1 reset mid-operation
    wr_ctrl(32'h0303_0303, "R3 set before reset");
    rst_ni = 1'b0;
    #1;
    check("R1 async reset clears", 32'(req_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1; exp_req = '0;
    @(negedge clk_i);
    rd(A_CTRL, rd_val);
    check("R1 ctrl after second reset", rd_val, 32'h0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule